// File: doc/BRIEF.md
# Prime-Base Digit Sum Engine

This block sums the digits of an unsigned binary integer written in a chosen radix. It does not convert the number into digits ahead of time. It divides repeatedly instead. Each division step returns a quotient and a remainder. The remainder is the next digit, working up from the lowest, and it goes straight into a running total. The quotient becomes the dividend for the next step. The loop stops when the quotient reaches zero. The divider is a restoring shift-subtract unit that retires one quotient bit per clock, so every digit costs the same, known number of cycles.

A second mode wraps the summer in a search filter. The reference is the binary popcount of the value. The engine computes the digit sum in radix 3, 5, 7, 11 and 13, in that order. It stops at the first radix whose sum differs from the reference and skips the rest. A single result pulse then reports whether every radix agreed, which radix the search stopped at, and the digit sum seen there. A host can use this to screen candidate integers, one request at a time.

Top module: `dsum_top`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `match_o` are low, and `sum_o` and `stop_base_o` are zero.
- R2: With `mode_i`=0, the result is the sum of the digits of `value_i` in radix `base_i`. The digits come from repeated quotient and remainder steps, least significant digit first.
- R3: A value of zero counts as the single digit 0, so its digit sum is 0 in every radix and in both modes.
- R4: A `base_i` of 0 or 1 is treated as radix 2. The radix-2 digit sum equals the popcount of the value.
- R5: Let W be the value width, D the digit count of the value in a radix (D=0 for a value of zero), and X the number of radices tried. The result takes the sum over the X radices of D·(W+2)+2 cycles, counted from the clock edge that accepts the start. `done_o` is high for exactly one cycle.
- R6: `busy_o` is high from the cycle after an accepted start up to the cycle in which `done_o` rises, and is low in that cycle. A start that arrives while `busy_o` is high is ignored and changes neither the result nor the timing.
- R7: With `mode_i`=1, the radices are tried in the order 3, 5, 7, 11, 13. At the first radix whose digit sum differs from the popcount, the search stops: `match_o`=0, `stop_base_o` is that radix, and `sum_o` is its digit sum.
- R8: With `mode_i`=1, if all five radices agree with the popcount, `match_o`=1, `stop_base_o`=13 and `sum_o` is the radix-13 digit sum.
- R9: With `mode_i`=0, `stop_base_o` is the radix actually used, and `match_o` shows whether the digit sum equals the popcount.
- R10: Every digit the divider produces is less than the radix in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a computation; accepted only when idle |
| mode_i | input | 1 | 0 = one digit sum in radix `base_i`, 1 = prime-radix screen |
| value_i | input | W | Unsigned value to process |
| base_i | input | BW | Radix for mode 0 (0 and 1 are treated as 2) |
| busy_o | output | 1 | High while a request is in progress |
| done_o | output | 1 | One-cycle pulse marking the result as valid |
| sum_o | output | SW | Digit sum at the final radix |
| match_o | output | 1 | Digit sum(s) equal to the popcount |
| stop_base_o | output | BW | Radix at which the computation ended |

## Verification
Some properties can be checked on every cycle. The assertions cover these: `done_o` is a one-cycle pulse that ends a busy period, and a start seen while busy leaves the captured request alone. Every remainder the divider produces is below its divisor. A screen that ends in a full match reports radix 13, and a single-radix request reports the clamped radix it was given. Other behaviour depends on the numbers and can only be shown by the bench's scenarios. That covers the exact digit sums, the early exit landing on the right prime, and the cycle count that grows with the digit count per radix. The bench predicts all of these from its own arithmetic and compares `busy_o` and `done_o` with that prediction on every clock.

// File: rtl/dsum_pkg.sv
package dsum_pkg;

  localparam int NUM_CHECK = 5;

  function automatic int unsigned popcnt64(input logic [63:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 64; i++) c += {31'd0, v[i]};
    return c;
  endfunction

  // radix tried at a given position of the screen, ascending primes
  function automatic int unsigned check_base(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 5;
      2:       return 7;
      3:       return 11;
      default: return 13;
    endcase
  endfunction

endpackage

// File: rtl/dsum_divider.sv
module dsum_divider #(
  parameter int W  = 16,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [BW-1:0] divisor,
  output logic          done,
  output logic [W-1:0]  quot,
  output logic [BW-1:0] rem,
  output logic [BW-1:0] div_k
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q;
  logic [BW-1:0] rem_q, k_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [BW:0]   trial;
  logic          fits;
  logic [BW-1:0] rem_nxt;

  always_comb begin
    trial   = {rem_q, acc_q[W-1]};
    fits    = trial >= {1'b0, k_q};
    rem_nxt = fits ? BW'(trial - {1'b0, k_q}) : trial[BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      k_q    <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        acc_q <= dividend;
        rem_q <= '0;
        k_q   <= divisor;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        acc_q <= {acc_q[W-2:0], fits};
        rem_q <= rem_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done  = done_q;
  assign quot  = acc_q;
  assign rem   = rem_q;
  assign div_k = k_q;
endmodule

// File: rtl/dsum_engine.sv
module dsum_engine #(
  parameter int W  = 16,
  parameter int BW = 5,
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  value,
  input  logic [BW-1:0] base,
  output logic          done,
  output logic [SW-1:0] sum,
  output logic          dig_valid,
  output logic [BW-1:0] dig_val,
  output logic [BW-1:0] dig_base
);
  typedef enum logic [1:0] {E_IDLE, E_LAUNCH, E_WAIT} estate_t;

  estate_t       st_q;
  logic [W-1:0]  n_q;
  logic [BW-1:0] k_q;
  logic [SW-1:0] sum_q;
  logic          done_q;
  logic          div_go, div_done;
  logic [W-1:0]  div_quot;
  logic [BW-1:0] div_rem, div_k;

  assign div_go = (st_q == E_LAUNCH);

  dsum_divider #(.W(W), .BW(BW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go),
    .dividend(n_q), .divisor(k_q),
    .done(div_done), .quot(div_quot), .rem(div_rem), .div_k(div_k)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      n_q    <= '0;
      k_q    <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        E_IDLE: if (start) begin
          k_q   <= base;
          sum_q <= '0;
          n_q   <= value;
          if (value == '0) done_q <= 1'b1;
          else             st_q   <= E_LAUNCH;
        end
        E_LAUNCH: st_q <= E_WAIT;
        E_WAIT: if (div_done) begin
          sum_q <= sum_q + SW'(div_rem);
          if (div_quot == '0) begin
            done_q <= 1'b1;
            st_q   <= E_IDLE;
          end else begin
            n_q  <= div_quot;
            st_q <= E_LAUNCH;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign sum       = sum_q;
  assign dig_valid = div_done;
  assign dig_val   = div_rem;
  assign dig_base  = div_k;
endmodule

// File: rtl/dsum_top.sv
module dsum_top #(
  parameter int W  = 16,
  parameter int BW = 5,
  localparam int SW = $clog2(W * ((1 << BW) - 2) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [W-1:0]  value_i,
  input  logic [BW-1:0] base_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] sum_o,
  output logic          match_o,
  output logic [BW-1:0] stop_base_o
);
  import dsum_pkg::*;

  localparam int IW = $clog2(NUM_CHECK);

  typedef enum logic [1:0] {T_IDLE, T_LAUNCH, T_WAIT} tstate_t;

  tstate_t       st_q;
  logic          cap_mode;
  logic [W-1:0]  cap_value;
  logic [BW-1:0] cap_base;
  logic [IW-1:0] idx_q;
  logic [BW-1:0] eng_base;
  logic [SW-1:0] ref_pop;
  logic          eng_go, eng_done;
  logic [SW-1:0] eng_sum;
  logic          dig_valid;
  logic [BW-1:0] dig_val, dig_base;
  logic          done_q, match_q;
  logic [SW-1:0] sum_q;
  logic [BW-1:0] stop_q;

  assign eng_go   = (st_q == T_LAUNCH);
  assign eng_base = cap_mode ? BW'(check_base(32'(idx_q))) : cap_base;
  assign ref_pop  = SW'(popcnt64(64'(cap_value)));

  dsum_engine #(.W(W), .BW(BW), .SW(SW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_go),
    .value(cap_value), .base(eng_base),
    .done(eng_done), .sum(eng_sum),
    .dig_valid(dig_valid), .dig_val(dig_val), .dig_base(dig_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= T_IDLE;
      cap_mode  <= 1'b0;
      cap_value <= '0;
      cap_base  <= '0;
      idx_q     <= '0;
      done_q    <= 1'b0;
      match_q   <= 1'b0;
      sum_q     <= '0;
      stop_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        T_IDLE: if (start_i) begin
          cap_mode  <= mode_i;
          cap_value <= value_i;
          cap_base  <= (base_i < BW'(2)) ? BW'(2) : base_i;
          idx_q     <= '0;
          st_q      <= T_LAUNCH;
        end
        T_LAUNCH: st_q <= T_WAIT;
        T_WAIT: if (eng_done) begin
          if (!cap_mode || eng_sum != ref_pop || idx_q == IW'(NUM_CHECK - 1)) begin
            done_q  <= 1'b1;
            sum_q   <= eng_sum;
            match_q <= (eng_sum == ref_pop);
            stop_q  <= eng_base;
            st_q    <= T_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= T_LAUNCH;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != T_IDLE);
  assign done_o      = done_q;
  assign sum_o       = sum_q;
  assign match_o     = match_q;
  assign stop_base_o = stop_q;
endmodule

// File: rtl/dsum_checker.sv
module dsum_checker #(
  parameter int W  = 16,
  parameter int BW = 5,
  parameter int SW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          match_o,
  input logic [SW-1:0] sum_o,
  input logic [BW-1:0] stop_base_o,
  input logic          cap_mode,
  input logic [W-1:0]  cap_value,
  input logic [BW-1:0] cap_base,
  input logic          dig_valid,
  input logic [BW-1:0] dig_val,
  input logic [BW-1:0] dig_base
);
  a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r6_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(cap_value));

  a_r10_digit_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (dig_val < dig_base));

  a_r3_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_value == '0) |-> (sum_o == '0));

  a_r8_full_match_at_13: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_mode && match_o) |-> (stop_base_o == BW'(13)));

  a_r7_stop_is_prime: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_mode) |-> (stop_base_o == BW'(3) || stop_base_o == BW'(5) ||
                              stop_base_o == BW'(7) || stop_base_o == BW'(11) ||
                              stop_base_o == BW'(13)));

  a_r9_single_radix: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_mode) |-> (stop_base_o == cap_base));
endmodule

bind dsum_top dsum_checker #(.W(W), .BW(BW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .match_o(match_o), .sum_o(sum_o),
  .stop_base_o(stop_base_o), .cap_mode(cap_mode), .cap_value(cap_value),
  .cap_base(cap_base), .dig_valid(dig_valid), .dig_val(dig_val),
  .dig_base(dig_base)
);

// File: tb/tb_dsum_top.sv
module tb_dsum_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int BW = 5;
  localparam int SUMW = $clog2(W * 30 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic [W-1:0]  value_i = '0;
  logic [BW-1:0] base_i = '0;
  logic busy_o, done_o, match_o;
  logic [SUMW-1:0] sum_o;
  logic [BW-1:0]   stop_base_o;

  int tests = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  logic exp_busy = 1'b0, exp_done = 1'b0;
  int   exp_cnt = 0, exp_sum = 0, exp_stop = 0;
  logic exp_match = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsum_top #(.W(W), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .value_i(value_i), .base_i(base_i), .busy_o(busy_o), .done_o(done_o),
    .sum_o(sum_o), .match_o(match_o), .stop_base_o(stop_base_o)
  );

  function automatic int digsum(int v, int b);
    int s = 0;
    while (v > 0) begin s += v % b; v = v / b; end
    return s;
  endfunction

  function automatic int ndigits(int v, int b);
    int d = 0;
    while (v > 0) begin d++; v = v / b; end
    return d;
  endfunction

  function automatic int ones(int v);
    return digsum(v, 2);
  endfunction

  // behavioural prediction: result fields and total latency
  task automatic predict(input logic m, input int v, input int b,
                         output int s, output logic mt, output int stp, output int lat);
    int primes[5] = '{3, 5, 7, 11, 13};
    int r = ones(v);
    lat = 0;
    if (!m) begin
      if (b < 2) b = 2;            // R4 clamp
      s = digsum(v, b); stp = b; mt = (s == r);
      lat = ndigits(v, b) * (W + 2) + 2;
    end else begin
      s = 0; stp = 0; mt = 1'b1;
      foreach (primes[i]) begin
        s = digsum(v, primes[i]);
        stp = primes[i];
        lat += ndigits(v, primes[i]) * (W + 2) + 2;
        if (s != r) begin mt = 1'b0; break; end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_busy <= 1'b0; exp_done <= 1'b0; exp_cnt <= 0;
    end else begin
      exp_done <= 1'b0;
      if (exp_busy) begin
        if (exp_cnt == 1) begin exp_busy <= 1'b0; exp_done <= 1'b1; end
        exp_cnt <= exp_cnt - 1;
      end else if (start_i) begin
        int s, stp, lat; logic mt;
        predict(mode_i, int'(value_i), int'(base_i), s, mt, stp, lat);
        exp_sum <= s; exp_match <= mt; exp_stop <= stp;
        exp_cnt <= lat; exp_busy <= 1'b1;
      end
    end
  end

  // per-cycle comparison against the model (R5, R6) and results on done
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (busy_o !== exp_busy || done_o !== exp_done) begin
        fails++;
        $display("FAIL R5/R6 (%s) busy/done: actual %b/%b expected %b/%b",
                 cur_req, busy_o, done_o, exp_busy, exp_done);
      end
      if (exp_done) begin
        tests++;
        if (int'(sum_o) != exp_sum || match_o !== exp_match || int'(stop_base_o) != exp_stop) begin
          fails++;
          $display("FAIL %s result sum/match/stop: actual %0d/%b/%0d expected %0d/%b/%0d",
                   cur_req, sum_o, match_o, stop_base_o, exp_sum, exp_match, exp_stop);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run(input string req, input logic m, input int v, input int b);
    cur_req = req;
    @(negedge clk);
    start_i = 1'b1; mode_i = m; value_i = W'(v); base_i = BW'(b);
    @(negedge clk);
    start_i = 1'b0;
    while (!exp_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;  // R1 reset state
    if (busy_o !== 1'b0 || done_o !== 1'b0 || match_o !== 1'b0 || sum_o !== '0 || stop_base_o !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual busy=%b done=%b match=%b sum=%0d stop=%0d expected all 0",
               busy_o, done_o, match_o, sum_o, stop_base_o);
    end

    run("R2", 1'b0, 12345, 10);
    run("R2", 1'b0, 40000, 17);
    run("R2", 1'b0, 255, 31);
    run("R10", 1'b0, 65535, 3);
    run("R3", 1'b0, 0, 7);
    run("R4", 1'b0, 65535, 2);
    run("R4", 1'b0, 100, 0);
    run("R4", 1'b0, 100, 1);
    run("R9", 1'b0, 21, 5);
    run("R3", 1'b1, 0, 0);
    run("R8", 1'b1, 1, 0);
    run("R7", 1'b1, 2, 0);
    run("R7", 1'b1, 21, 0);
    run("R7", 1'b1, 6, 0);
    run("R7", 1'b1, 65535, 0);

    // R6: second start during a run must be ignored
    cur_req = "R6";
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b0; value_i = W'(999); base_i = BW'(10);
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    start_i = 1'b1; mode_i = 1'b1; value_i = W'(6); base_i = BW'(3);
    @(negedge clk);
    start_i = 1'b0;
    while (!exp_done) @(negedge clk);
    @(negedge clk);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule